// File: doc/BRIEF.md
# Bit-Banged Two-Wire Line Controller

This peripheral lets software run a two-wire (I2C) bus by moving the clock and data lines one step at a time. It holds a two-bit line-state register that controls two open-drain pads. A register bus with a single-cycle strobe reaches it through a 4 KB byte-offset window. One offset raises line bits, and a second offset lowers them. Software can therefore move SCL or SDA without first reading the register back.

The SDA pad is sampled back through a two-flop synchroniser. A fresh copy of the synchronised level is latched after every accepted write, once the new pad drive has had time to pass through the synchroniser. A read returns the commanded SCL level together with that latched SDA level, one cycle after the strobe. Any access that does not decode gives a one-cycle error pulse and changes nothing else.

The bus has no valid/ready back-pressure. Every strobed cycle is accepted, and the block never stalls the requester.

Top module: `twi_bang_ctrl`

## Requirements
- R1: While reset is asserted, and until the first write, both pads are released (`scl_oe` = 0, `sda_oe` = 0), `bus_rdata` is zero and `bus_err` is low. The latched SDA level starts at 1.
- R2: A write (`bus_sel`=1, `bus_we`=1) to offset 0x000 ORs `bus_wdata[1:0]` into the line-state register from the next clock edge. Line-state bits that the data does not set keep their value, and `bus_wdata[31:2]` has no effect.
- R3: A write to offset 0x004 clears each line-state bit whose matching bit in `bus_wdata[1:0]` is 1, and leaves the others unchanged. `bus_wdata[31:2]` has no effect.
- R4: Line-state bit 0 controls SCL and bit 1 controls SDA. When a bit is 1 its pad is released (output enable 0). When a bit is 0 its pad is driven (output enable 1). `scl_o` and `sda_o` are always 0.
- R5: A read (`bus_sel`=1, `bus_we`=0) at offset 0x000 makes `bus_rdata` valid in the following cycle only. Bit 0 holds line-state bit 0, bit 1 holds the latched SDA level, and bits 31:2 are zero. In every other cycle `bus_rdata` is zero.
- R6: `sda_i` passes through two synchronising flops. The latched SDA level takes the synchroniser output on the third clock edge after the edge that accepts a write. A later write restarts this count, and the latch does not change at any other time.
- R7: A strobed access at any other offset or direction sets `bus_err` high for exactly the following cycle. Examples are a read at 0x004, a write at 0x008, or any unaligned offset. Such an access changes neither the line state nor the latched SDA level, and `bus_rdata` stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle bad-access pulse |
| scl_oe | output | 1 | SCL pad drive enable |
| scl_o | output | 1 | SCL pad output value (always 0) |
| sda_oe | output | 1 | SDA pad drive enable |
| sda_o | output | 1 | SDA pad output value (always 0) |
| sda_i | input | 1 | SDA pad level |

## Verification
The hardest case to reach is when the latched SDA level disagrees with the live pad. This happens when a target pulls SDA low, or lets it go, with no write in between. It also happens when a read lands inside the three-cycle window after a write, before the new drive level has been latched.

The bench models an external target on the wired-AND pad and changes its level between accesses. It issues reads at several distances from the last write. It also mixes back-to-back random writes, reads and undecoded accesses, so the latch count is restarted while it is still running.

// File: rtl/twi_bang_pkg.sv
package twi_bang_pkg;
  localparam int OFS_RAISE = 'h000;
  localparam int OFS_LOWER = 'h004;
  localparam int NUM_LINES = 2;

  typedef struct packed {
    logic raise;
    logic lower;
    logic rd;
    logic bad;
  } acc_t;
endpackage

// File: rtl/twi_bang_decode.sv
module twi_bang_decode
  import twi_bang_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);
  localparam logic [ADDR_W-1:0] A_RAISE = ADDR_W'(OFS_RAISE);
  localparam logic [ADDR_W-1:0] A_LOWER = ADDR_W'(OFS_LOWER);

  always_comb begin
    acc.raise = sel &&  we && (addr == A_RAISE);
    acc.lower = sel &&  we && (addr == A_LOWER);
    acc.rd    = sel && !we && (addr == A_RAISE);
    acc.bad   = sel && !(acc.raise || acc.lower || acc.rd);
  end
endmodule

// File: rtl/twi_bang_sync.sv
module twi_bang_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= RESET_VAL;
      else if (i == 0) chain_q[i] <= d;
      else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/twi_bang_ctrl.sv
module twi_bang_ctrl
  import twi_bang_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              scl_oe,
  output logic              scl_o,
  output logic              sda_oe,
  output logic              sda_o,
  input  logic              sda_i
);
  localparam int CAP_DELAY = SYNC_STAGES + 1;
  localparam int CNT_W     = $clog2(CAP_DELAY + 1);

  acc_t                 acc;
  logic [NUM_LINES-1:0] line_q;
  logic [NUM_LINES-1:0] pad_oe;
  logic                 sda_sync;
  logic                 sda_cap_q;
  logic [CNT_W-1:0]     cap_cnt_q;
  logic                 wr_any;
  logic                 unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_LINES];

  twi_bang_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel  (bus_sel),
    .we   (bus_we),
    .addr (bus_addr),
    .acc  (acc)
  );

  twi_bang_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sda_i),
    .q     (sda_sync)
  );

  assign wr_any = acc.raise || acc.lower;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '1;
    end else if (acc.raise) begin
      line_q <= line_q | bus_wdata[NUM_LINES-1:0];
    end else if (acc.lower) begin
      line_q <= line_q & ~bus_wdata[NUM_LINES-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_cnt_q <= '0;
      sda_cap_q <= 1'b1;
    end else begin
      if (cap_cnt_q == CNT_W'(1)) sda_cap_q <= sda_sync;
      if (wr_any) cap_cnt_q <= CNT_W'(CAP_DELAY);
      else if (cap_cnt_q != '0) cap_cnt_q <= cap_cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= acc.rd ? {{(DATA_W-2){1'b0}}, sda_cap_q, line_q[0]} : '0;
      bus_err   <= acc.bad;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_pad
    assign pad_oe[i] = ~line_q[i];
  end

  assign scl_oe = pad_oe[0];
  assign sda_oe = pad_oe[1];
  assign scl_o  = 1'b0;
  assign sda_o  = 1'b0;
endmodule

// File: rtl/twi_bang_ctrl_chk.sv
module twi_bang_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              scl_oe,
  input logic              scl_o,
  input logic              sda_oe,
  input logic              sda_o
);
  // R2
  raise_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == '0 && bus_wdata[0]) |=> !scl_oe);

  // R3
  lower_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'(4) && bus_wdata[1]) |=> sda_oe);

  // R4
  od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o == 1'b0) && (sda_o == 1'b0));

  // R5
  rdata_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:2] == '0);

  // R5
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> bus_rdata == '0);

  // R7
  err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel));

  // R7
  bad_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr != '0 && bus_addr != ADDR_W'(4))
      |=> ($stable(scl_oe) && $stable(sda_oe)));
endmodule

bind twi_bang_ctrl twi_bang_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .scl_oe    (scl_oe),
  .scl_o     (scl_o),
  .sda_oe    (sda_oe),
  .sda_o     (sda_o)
);

// File: tb/twi_bang_ctrl_bench.sv
module twi_bang_ctrl_bench;
  localparam int CAP_DELAY = 3;   // R6: third edge after a write

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0, ext = 1'b1, live = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         err, scl_oe, scl_o, sda_oe, sda_o;
  wire         sda_pin = (sda_oe ? sda_o : 1'b1) & ext;

  int vecs = 0, errs = 0;

  always #10 clk = ~clk;

  twi_bang_ctrl u_twi_bang_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err), .scl_oe(scl_oe),
    .scl_o(scl_o), .sda_oe(sda_oe), .sda_o(sda_o), .sda_i(sda_pin)
  );

  // behavioural reference
  logic [1:0]  m_line;
  logic        m_s1, m_s2, m_cap, m_err;
  int          m_cnt;
  logic [31:0] m_rdata;

  always @(posedge clk) begin : model
    logic pin, is_set, is_clr, is_rd;
    if (!rst_n) begin
      m_line = 2'b11; m_s1 = 1; m_s2 = 1; m_cap = 1; m_cnt = 0;
      m_rdata = 0; m_err = 0;
    end else begin
      pin    = m_line[1] & ext;
      is_set = sel && we && addr == 12'h000;
      is_clr = sel && we && addr == 12'h004;
      is_rd  = sel && !we && addr == 12'h000;
      m_rdata = is_rd ? {30'b0, m_cap, m_line[0]} : 32'b0;
      m_err   = sel && !(is_set || is_clr || is_rd);
      if (m_cnt == 1) m_cap = m_s2;
      m_s2 = m_s1;
      m_s1 = pin;
      m_cnt = (is_set || is_clr) ? CAP_DELAY : (m_cnt > 0 ? m_cnt - 1 : 0);
      if (is_set) m_line = m_line | wdata[1:0];
      else if (is_clr) m_line = m_line & ~wdata[1:0];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && live) begin
      chk("R2/R3/R4 scl_oe", {31'b0, scl_oe}, {31'b0, ~m_line[0]});
      chk("R2/R3/R4 sda_oe", {31'b0, sda_oe}, {31'b0, ~m_line[1]});
      chk("R4 pad values", {30'b0, scl_o, sda_o}, 32'b0);
      chk("R5/R6 rdata", rdata, m_rdata);
      chk("R7 err", {31'b0, err}, {31'b0, m_err});
    end
  end

  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = w; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : stim
    idle(3);
    // R1 reset state
    chk("R1 reset oe", {30'b0, scl_oe, sda_oe}, 32'b0);
    chk("R1 reset rdata", rdata, 32'b0);
    chk("R1 reset err", {31'b0, err}, 32'b0);
    rst_n = 1; live = 1;
    idle(2);
    acc(0, 12'h000, 0);                     // R1 idle readback, R5
    acc(1, 12'h004, 32'h1);                 // R3 SCL low
    acc(1, 12'h004, 32'h2);                 // R3 SDA low
    idle(4); acc(0, 12'h000, 0);            // R6 capture of driven low
    acc(1, 12'h000, 32'hFFFF_FFFC);         // R2 upper bits ignored
    acc(1, 12'h004, 32'hFFFF_FFFC);         // R3 upper bits ignored
    acc(1, 12'h000, 32'h3);                 // R2 release both
    acc(0, 12'h000, 0);                     // R6 read inside window
    idle(3); acc(0, 12'h000, 0);
    ext = 0; idle(5); acc(0, 12'h000, 0);   // R6 stale without write
    acc(1, 12'h000, 32'h0); idle(4); acc(0, 12'h000, 0); // R6 target low seen
    ext = 1;
    acc(1, 12'h008, 32'h0);                 // R7 bad write
    acc(0, 12'h004, 0);                     // R7 bad read
    acc(1, 12'hFFC, 32'h0);                 // R7 top of window
    acc(1, 12'h001, 32'h3);                 // R7 unaligned
    for (int i = 0; i < 2000; i++) begin
      int pick;
      @(negedge clk);
      pick  = $urandom_range(0, 9);
      sel   = (pick != 0);
      we    = $urandom_range(0, 1);
      addr  = (pick < 4) ? 12'h000 : (pick < 7) ? 12'h004 : 12'($urandom);
      wdata = $urandom;
      if ($urandom_range(0, 7) == 0) ext = ~ext;
    end
    @(negedge clk); sel = 0; we = 0;
    idle(6);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule